// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front-End

This block is the software-visible register file of a 16550-compatible serial port. It sits on a simple synchronous byte bus that carries an address, read and write strobes and 8-bit data. Each register offset is multiplied by a configurable stride to form its bus address. The block holds the divisor latch, line control, FIFO control, modem control and one general byte register. It reports line status and modem status. It does no bit-level framing itself. It hands bytes to an external serializer and takes bytes from an external deserializer over valid/ready streams. It exports the divisor and line settings that those engines need.

A transmit FIFO and a receive FIFO sit between the bus and the streams. Their usable depth follows the FIFO control bits: one entry when disabled, a standard depth when enabled, and an extended depth when the extended mode is also selected. Both FIFOs take the same depth. The modem input pins pass through a two-flop synchronizer before software can see them.

Top module: `uart_regfront`

## Requirements
- R1: Register n sits at bus address n*STRIDE. An access at an address that is not a multiple of STRIDE, or at offset 7 or above, is ignored and reads 0x00. Read data appears on busRdata in the cycle after busRd.
- R2: While bit 7 of the line control register (the divisor-access bit) is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The divisor output shows the latch. A write to offset 0 in this state does not push the transmit FIFO.
- R3: While the divisor-access bit is 0, offset 1 is an independent read/write byte that leaves the divisor untouched.
- R4: Offset 3 is the 8-bit line control register, read/write. lineCtrl outputs its bits 5:0: bits 1:0 hold the data length minus 5, bit 2 selects the longer stop setting, and bits 5:3 select parity (0 none, 1 odd, 3 even, 5 mark, 7 space).
- R5: Offset 4 is modem control. Bit 0 drives dtrOut and bit 1 drives rtsOut. Other bits read as 0.
- R6: Offset 2 is FIFO control. Bit 0 enables the FIFOs and bit 5 selects extended mode. Only these two bits are stored and read back. The depth of each FIFO is 1 when bit 0 is 0, DEPTH_STD when only bit 0 is 1, and DEPTH_EXT when both bits are 1.
- R7: A write to offset 2 with bit 0 equal to 0 empties both FIFOs in that cycle.
- R8: A write to offset 0 with the divisor-access bit at 0 pushes a byte to the transmit FIFO. The write is dropped when the FIFO is full. txValid is high while the FIFO holds data. Bytes leave on txData in write order, one per cycle in which txValid and txReady are both high.
- R9: rxReady is high while the receive FIFO is not full. A byte is accepted in each cycle in which rxValid and rxReady are both high. A read of offset 0 (divisor-access bit 0) returns and removes the oldest byte. On an empty FIFO it returns 0x00 and removes nothing.
- R10: Offset 5 is line status. Bit 0 = receive FIFO not empty. Bit 5 = transmit FIFO empty. Bit 6 = transmit FIFO empty and txShiftIdle high. Other bits read 0.
- R11: Offset 6 is modem status. Bits 4, 5, 6 and 7 show ctsIn, dsrIn, riIn and dcdIn through a two-flop synchronizer, so a pin change becomes visible to a read issued three or more cycles later. Bits 3:0 read 0.
- R12: After reset, line control, divisor, FIFO control, modem control and the offset 1 byte are all 0x00, both FIFOs are empty, and busRdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, one cycle after busRd |
| lineCtrl | output | 6 | Line settings for the serializer |
| divisor | output | 16 | Baud divisor |
| dtrOut | output | 1 | Data terminal ready |
| rtsOut | output | 1 | Request to send |
| txData | output | 8 | Transmit stream byte |
| txValid | output | 1 | Transmit stream valid |
| txReady | input | 1 | Serializer accepts a byte |
| txShiftIdle | input | 1 | Serializer shift register empty |
| rxData | input | 8 | Receive stream byte |
| rxValid | input | 1 | Receive stream valid |
| rxReady | output | 1 | Receive FIFO can accept |
| ctsIn | input | 1 | Clear-to-send pin |
| dsrIn | input | 1 | Data-set-ready pin |
| riIn | input | 1 | Ring indicator pin |
| dcdIn | input | 1 | Carrier detect pin |

## Verification
A wrong FIFO count or depth shows on the streams in the same cycle: txValid or rxReady takes the wrong level, or a byte is lost or duplicated on txData. The same fault reaches busRdata one cycle after a status or receive-buffer read. A wrong divisor-access bit shows as a misrouted access: a write that should set the divisor appears on txData instead, or the divisor output fails to change the cycle after the write. A synchronizer with the wrong depth shows as a modem status read that changes one cycle too early or too late after a pin edge.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_RX, SEL_DIVLO, SEL_DIVHI, SEL_AUX,
    SEL_FCTL, SEL_LCTL, SEL_MCTL, SEL_LSTAT, SEL_MSTAT
  } rdsel_e;

  typedef struct packed {
    logic   wrDivLo;
    logic   wrDivHi;
    logic   wrAux;
    logic   wrFctl;
    logic   wrLctl;
    logic   wrMctl;
    logic   txPush;
    logic   rxPop;
    logic   rdEn;
    rdsel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count >= cap);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 4,
  localparam int SH = $clog2(STRIDE)
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              dlab,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(STRIDE - 1);

  logic [ADDR_W-1:0] offs;
  logic [2:0]        off3;
  logic              hit;

  assign offs = busAddr >> SH;
  assign off3 = offs[2:0];
  assign hit  = ((busAddr & LOW_MASK) == '0) && ((offs >> 3) == '0);

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    stb.rdEn  = busRd;
    if (hit) begin
      unique case (off3)
        3'd0: if (dlab) begin
                stb.wrDivLo = busWr;
                if (busRd) stb.rdSel = SEL_DIVLO;
              end else begin
                stb.txPush = busWr;
                stb.rxPop  = busRd;
                if (busRd) stb.rdSel = SEL_RX;
              end
        3'd1: if (dlab) begin
                stb.wrDivHi = busWr;
                if (busRd) stb.rdSel = SEL_DIVHI;
              end else begin
                stb.wrAux = busWr;
                if (busRd) stb.rdSel = SEL_AUX;
              end
        3'd2: begin stb.wrFctl = busWr; if (busRd) stb.rdSel = SEL_FCTL;  end
        3'd3: begin stb.wrLctl = busWr; if (busRd) stb.rdSel = SEL_LCTL;  end
        3'd4: begin stb.wrMctl = busWr; if (busRd) stb.rdSel = SEL_MCTL;  end
        3'd5: if (busRd) stb.rdSel = SEL_LSTAT;
        3'd6: if (busRd) stb.rdSel = SEL_MSTAT;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart_rf_datapath.sv
module uart_rf_datapath
  import uart_rf_pkg::*;
#(
  parameter int DEPTH_STD = 16,
  parameter int DEPTH_EXT = 64,
  localparam int CW = $clog2(DEPTH_EXT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  strobe_t     stb,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  output logic        dlab,
  output logic [5:0]  lineCtrl,
  output logic [15:0] divisor,
  output logic        dtrOut,
  output logic        rtsOut,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        txReady,
  input  logic        txShiftIdle,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  output logic        rxReady,
  input  logic        ctsIn,
  input  logic        dsrIn,
  input  logic        riIn,
  input  logic        dcdIn
);
  logic [7:0]    lctl, auxReg, rdNext, rxHead;
  logic [15:0]   divLatch;
  logic [1:0]    mctl;
  logic          fifoEn, fifoExt, flush;
  logic [3:0]    pinMeta, pinSync;
  logic [CW-1:0] cap;
  logic          txEmpty, txFull, rxEmpty, rxFull;

  assign dlab     = lctl[7];
  assign lineCtrl = lctl[5:0];
  assign divisor  = divLatch;
  assign dtrOut   = mctl[0];
  assign rtsOut   = mctl[1];
  assign flush    = stb.wrFctl && !busWdata[0];
  assign cap      = !fifoEn ? CW'(1) : (fifoExt ? CW'(DEPTH_EXT) : CW'(DEPTH_STD));
  assign txValid  = !txEmpty;
  assign rxReady  = !rxFull;

  uart_rf_fifo #(.DEPTH(DEPTH_EXT), .W(8)) txFifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .push(stb.txPush), .pop(txValid && txReady), .din(busWdata),
    .dout(txData), .empty(txEmpty), .full(txFull)
  );

  uart_rf_fifo #(.DEPTH(DEPTH_EXT), .W(8)) rxFifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .push(rxValid && rxReady), .pop(stb.rxPop), .din(rxData),
    .dout(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lctl     <= '0;
      auxReg   <= '0;
      divLatch <= '0;
      mctl     <= '0;
      fifoEn   <= 1'b0;
      fifoExt  <= 1'b0;
      pinMeta  <= '0;
      pinSync  <= '0;
      busRdata <= '0;
    end else begin
      if (stb.wrLctl)  lctl           <= busWdata;
      if (stb.wrAux)   auxReg         <= busWdata;
      if (stb.wrDivLo) divLatch[7:0]  <= busWdata;
      if (stb.wrDivHi) divLatch[15:8] <= busWdata;
      if (stb.wrMctl)  mctl           <= busWdata[1:0];
      if (stb.wrFctl) begin
        fifoEn  <= busWdata[0];
        fifoExt <= busWdata[5];
      end
      pinMeta <= {dcdIn, riIn, dsrIn, ctsIn};
      pinSync <= pinMeta;
      if (stb.rdEn) busRdata <= rdNext;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_RX:    rdNext = rxEmpty ? 8'h00 : rxHead;
      SEL_DIVLO: rdNext = divLatch[7:0];
      SEL_DIVHI: rdNext = divLatch[15:8];
      SEL_AUX:   rdNext = auxReg;
      SEL_FCTL:  rdNext = {2'b00, fifoExt, 4'b0000, fifoEn};
      SEL_LCTL:  rdNext = lctl;
      SEL_MCTL:  rdNext = {6'b0, mctl};
      SEL_LSTAT: rdNext = {1'b0, txEmpty && txShiftIdle, txEmpty, 4'b0000, !rxEmpty};
      SEL_MSTAT: rdNext = {pinSync, 4'b0000};
      default:   rdNext = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STRIDE    = 4,
  parameter int DEPTH_STD = 16,
  parameter int DEPTH_EXT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic [5:0]        lineCtrl,
  output logic [15:0]       divisor,
  output logic              dtrOut,
  output logic              rtsOut,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic              txShiftIdle,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              riIn,
  input  logic              dcdIn
);
  strobe_t stb;
  logic    dlab;

  uart_rf_ctrl #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) ctrl (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .dlab(dlab), .stb(stb)
  );

  uart_rf_datapath #(.DEPTH_STD(DEPTH_STD), .DEPTH_EXT(DEPTH_EXT)) dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busWdata(busWdata), .busRdata(busRdata),
    .dlab(dlab), .lineCtrl(lineCtrl), .divisor(divisor), .dtrOut(dtrOut), .rtsOut(rtsOut),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txShiftIdle(txShiftIdle),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .riIn(riIn), .dcdIn(dcdIn)
  );
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        busWdata,
  input logic              dlab,
  input logic [5:0]        lineCtrl,
  input logic [15:0]       divisor,
  input logic              dtrOut,
  input logic              rtsOut,
  input logic              txValid,
  input logic              rxReady
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FCTL = ADDR_W'(2 * STRIDE);
  localparam logic [ADDR_W-1:0] A_LCTL = ADDR_W'(3 * STRIDE);
  localparam logic [ADDR_W-1:0] A_MCTL = ADDR_W'(4 * STRIDE);

  // R4
  lctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == A_LCTL) |=> (lineCtrl == $past(busWdata[5:0])));

  // R5
  mctl_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == A_MCTL) |=> (dtrOut == $past(busWdata[0]) && rtsOut == $past(busWdata[1])));

  // R2
  div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == A_DATA && dlab) |=> (divisor[7:0] == $past(busWdata) && !txValid));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == A_FCTL && !busWdata[0]) |=> (!txValid && rxReady));
endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .dlab(dlab), .lineCtrl(lineCtrl), .divisor(divisor), .dtrOut(dtrOut), .rtsOut(rtsOut),
  .txValid(txValid), .rxReady(rxReady)
);

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;
  localparam int ADDR_W = 8;
  localparam int STRIDE = 4;
  localparam int DSTD   = 16;
  localparam int DEXT   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = '0, busRdata, txData, rxData = '0;
  logic [5:0] lineCtrl;
  logic [15:0] divisor;
  logic dtrOut, rtsOut, txValid, rxReady;
  logic txReady = 1'b0, txShiftIdle = 1'b1, rxValid = 1'b0;
  logic ctsIn = 1'b0, dsrIn = 1'b0, riIn = 1'b0, dcdIn = 1'b0;

  always #10 clk = ~clk;

  uart_regfront #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .DEPTH_STD(DSTD), .DEPTH_EXT(DEXT)) dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .lineCtrl(lineCtrl), .divisor(divisor),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .txData(txData), .txValid(txValid), .txReady(txReady),
    .txShiftIdle(txShiftIdle), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .ctsIn(ctsIn), .dsrIn(dsrIn), .riIn(riIn), .dcdIn(dcdIn)
  );

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [7:0] txQ[$], rxQ[$], rdExpQ[$];
  string rdTagQ[$];
  int mTxCnt = 0, mCap = 1;
  bit mDlab = 0;
  logic rdPending = 1'b0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  endtask

  // Driver: bus write, updating the bench's own model
  task automatic wrRaw(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic wr(input int off, input logic [7:0] d);
    if (off == 0 && !mDlab) begin
      if (mTxCnt < mCap) begin txQ.push_back(d); mTxCnt++; end
    end
    if (off == 3) mDlab = d[7];
    if (off == 2) begin
      mCap = !d[0] ? 1 : (d[5] ? DEXT : DSTD);
      if (!d[0]) begin txQ.delete(); rxQ.delete(); mTxCnt = 0; end
    end
    wrRaw(ADDR_W'(off * STRIDE), d);
  endtask

  task automatic rdRaw(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    rdExpQ.push_back(exp); rdTagQ.push_back(tag);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic rd(input int off, input logic [7:0] exp, input string tag);
    rdRaw(ADDR_W'(off * STRIDE), exp, tag);
  endtask

  task automatic rxSend(input logic [7:0] d);
    if (rxReady) rxQ.push_back(d);
    rxData = d; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic rxReadOne(input string tag);
    logic [7:0] e;
    e = (rxQ.size() > 0) ? rxQ.pop_front() : 8'h00;
    rd(0, e, tag);
  endtask

  task automatic drain(input int n);
    txReady = 1'b1;
    repeat (n) @(negedge clk);
    txReady = 1'b0;
  endtask

  // Monitor: read data and the transmit stream
  always @(posedge clk) rdPending <= busRd;

  always @(negedge clk) begin
    #1;
    if (rdPending) begin
      if (rdExpQ.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL R1 unexpected read data actual=%h expected=none", busRdata);
      end else check(rdTagQ.pop_front(), {8'h00, busRdata}, {8'h00, rdExpQ.pop_front()});
    end
    if (rst_n && txValid && txReady) begin
      if (txQ.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL R8 extra tx byte actual=%h expected=none", txData);
      end else begin
        mTxCnt--;
        check("R8 tx order", {8'h00, txData}, {8'h00, txQ.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 lineCtrl", {10'b0, lineCtrl}, 16'h0);
    check("R12 divisor", divisor, 16'h0);
    check("R12 dtr/rts", {14'b0, rtsOut, dtrOut}, 16'h0);
    check("R12 txValid", {15'b0, txValid}, 16'h0);
    check("R12 rxReady", {15'b0, rxReady}, 16'h1);
    check("R12 busRdata", {8'h0, busRdata}, 16'h0);
    rd(5, 8'h60, "R10 reset line status");
    rd(2, 8'h00, "R12 fifo control");
    rd(1, 8'h00, "R12 aux byte");
    rd(6, 8'h00, "R11 reset modem status");

    // R4 line control
    wr(3, 8'h1B);
    check("R4 lineCtrl", {10'b0, lineCtrl}, 16'h001B);
    rd(3, 8'h1B, "R4 readback");

    // R2 divisor banking
    wr(3, 8'h83);
    wr(0, 8'h34);
    wr(1, 8'h12);
    check("R2 divisor", divisor, 16'h1234);
    check("R2 no tx push", {15'b0, txValid}, 16'h0);
    rd(0, 8'h34, "R2 div low");
    rd(1, 8'h12, "R2 div high");
    wr(3, 8'h03);
    // R3 aux byte
    rd(1, 8'h00, "R3 aux independent");
    wr(1, 8'h5A);
    rd(1, 8'h5A, "R3 aux readback");
    check("R3 divisor kept", divisor, 16'h1234);

    // R1 unaligned and out-of-range accesses
    wrRaw(ADDR_W'(3 * STRIDE + 1), 8'h3F);
    check("R1 unaligned write ignored", {10'b0, lineCtrl}, 16'h0003);
    rdRaw(ADDR_W'(3 * STRIDE + 2), 8'h00, "R1 unaligned read");
    rd(7, 8'h00, "R1 offset 7 read");

    // R5 modem control
    wr(4, 8'h03);
    check("R5 dtr/rts on", {14'b0, rtsOut, dtrOut}, 16'h3);
    wr(4, 8'hFE);
    check("R5 dtr off rts on", {14'b0, rtsOut, dtrOut}, 16'h2);
    rd(4, 8'h02, "R5 readback");

    // R6/R8 single-entry mode: second write dropped
    wr(0, 8'hA1);
    wr(0, 8'hA2);
    check("R8 txValid", {15'b0, txValid}, 16'h1);
    rd(5, 8'h00, "R10 tx busy status");
    drain(4);
    rd(5, 8'h60, "R10 tx empty status");
    txShiftIdle = 1'b0;
    rd(5, 8'h20, "R10 shifter busy");
    txShiftIdle = 1'b1;

    // R9 single-entry receive
    rxSend(8'h11);
    check("R9 rxReady full", {15'b0, rxReady}, 16'h0);
    rxSend(8'h22);
    rd(5, 8'h61, "R10 rx ready");
    rxReadOne("R9 rx pop");
    rd(5, 8'h60, "R10 rx empty");
    rxReadOne("R9 empty read");

    // R6 standard depth
    wr(2, 8'h01);
    rd(2, 8'h01, "R6 readback");
    for (int i = 0; i < DSTD + 1; i++) wr(0, 8'(8'h40 + i));
    drain(DSTD + 4);
    for (int i = 0; i < DSTD + 1; i++) rxSend(8'(8'h80 + i));
    check("R6 rx full at std depth", {15'b0, rxReady}, 16'h0);
    for (int i = 0; i < DSTD + 1; i++) rxReadOne("R9 rx fifo order");
    rd(5, 8'h60, "R10 rx drained");

    // R6 extended depth
    wr(2, 8'hFF);
    rd(2, 8'h21, "R6 only two bits kept");
    for (int i = 0; i < DEXT + 1; i++) wr(0, 8'(i));
    check("R8 tx full ext", {15'b0, txValid}, 16'h1);
    drain(DEXT + 4);

    // R7 flush
    wr(0, 8'hC1);
    wr(0, 8'hC2);
    rxSend(8'hD1);
    rxSend(8'hD2);
    wr(2, 8'h20);
    check("R7 tx flushed", {15'b0, txValid}, 16'h0);
    check("R7 rx ready", {15'b0, rxReady}, 16'h1);
    rd(5, 8'h60, "R7 status after flush");
    wr(2, 8'h01);
    rd(5, 8'h60, "R7 still empty after re-enable");

    // R11 modem status synchronizer
    ctsIn = 1'b1; riIn = 1'b1; dcdIn = 1'b1;
    rd(6, 8'h00, "R11 not yet visible");
    repeat (2) @(negedge clk);
    rd(6, 8'hD0, "R11 modem status");
    dsrIn = 1'b1; ctsIn = 1'b0;
    repeat (3) @(negedge clk);
    rd(6, 8'hE0, "R11 modem status 2");

    repeat (3) @(negedge clk);
    check("R8 all tx delivered", 16'(txQ.size()), 16'h0);
    report();
  end
endmodule